// File: doc/BRIEF.md
# Shared Address/Data Bus Cycle Sequencer

This block runs external read and write transfers for an internal requester over one set of wires that carries first the address and then the data. A transfer is made of four bus states, T1 to T4. Each state lasts a fixed number of system clocks. The external device can stretch a transfer by holding a ready line low, which inserts wait states between T3 and T4.

On the internal side, a requester presents an address, write data, a direction flag and a memory-or-I/O flag with a one-clock valid strobe. It receives the captured read data and a one-clock done pulse. On the external side, the block drives the shared bus through a separate output vector and an output-enable. It also drives an address latch enable, an active-low chip select, active-low read and write strobes, and active-low memory and I/O request lines, and it samples the ready input. External glue logic latches the address on the falling edge of the latch enable.

A request is taken only while the sequencer is idle. Address, data and flags are frozen at acceptance, so the requester may change its inputs during the transfer.

Top module: `mxb_bus_master`

## Requirements
- R1: A transfer accepted at clock edge E0 raises `done_o` for exactly one clock, starting at edge E0 + (4+W)·N, where N is `CLKS_PER_STATE` and W is the number of wait states. Bus state k (T1=0, T2=1, T3=2, each wait state in turn, then T4) covers the clocks from E0 + k·N up to the next state.
- R2: Throughout T1, `bus_o` carries the latched address zero-extended to the bus width, `bus_oe_o` is 1 and `cs_n_o` is 0. `ale_o` is 1 for the first N/2 clocks of T1 and 0 for the rest.
- R3: From T2 through the last wait state, a read (`req_we_i`=0) holds `rd_n_o` at 0 with `bus_oe_o` at 0. A write (`req_we_i`=1) holds `wr_n_o` at 0 with `bus_oe_o` at 1 and `bus_o` equal to the latched write data. The strobe that does not belong to the transfer stays at 1.
- R4: From T2 through T4, `mreq_n_o` is 0 when `req_io_i`=0 and `iorq_n_o` is 0 when `req_io_i`=1. The other line stays at 1.
- R5: No bus output changes value at any clock inside T3 compared with the last clock of T2.
- R6: `ready_i` passes through `SYNC_STAGES` registers. A wait state is inserted after T3, and after each wait state, when the registered ready value used at that state's last clock is 0. With S stages, W = 0 if the first edge at which ready is sampled high is at or before E0 + 3N − S. Otherwise W = ceil((H − 3N + S)/N), where E0 + H is that edge.
- R7: For a read, `rdata_o` takes the value on `bus_i` at the edge that enters T4 and keeps it until the next read captures.
- R8: For a write, `wr_n_o` is 1 during T4 while `bus_o` still carries the write data with `bus_oe_o`=1 and `cs_n_o`=0.
- R9: After reset and whenever the sequencer is idle, all active-low outputs are 1, and `ale_o`, `bus_oe_o`, `bus_o` and `done_o` are 0.
- R10: `req_valid_i` and the request fields are ignored unless the sequencer is idle. A request raised during a transfer neither alters the bus contents nor starts another transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| req_addr_i | input | ADDR_W | Transfer address |
| req_wdata_i | input | BUS_W | Write data |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| rdata_o | output | BUS_W | Captured read data |
| done_o | output | 1 | One-clock completion pulse |
| bus_o | output | BUS_W | Value driven onto the shared bus |
| bus_oe_o | output | 1 | Shared bus output-enable |
| bus_i | input | BUS_W | Value sampled from the shared bus |
| ale_o | output | 1 | Address latch enable, active high |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| mreq_n_o | output | 1 | Memory request, active low |
| iorq_n_o | output | 1 | I/O request, active low |
| ready_i | input | 1 | External ready, low requests wait states |

## Verification
Two events can fall on the same clock edge. The decision to insert a wait state can land on the edge that captures read data and ends the read strobe. The edge that releases a wait state can land on the edge that enters T4. The bench sweeps the clock at which ready rises across every position around the end of T3 and through several wait states, for each direction and address space. It drives a different value onto `bus_i` in every clock. The captured data and the clock at which the strobe rises then show whether capture and wait-state release happened on the same edge, as the arithmetic of R6 and R7 predicts.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5,
      ST_DONE = 3'd6
   } mxb_state_e;

   // true while the strobe window (T2..last wait state) is open
   function automatic logic in_strobe(input mxb_state_e s);
      return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
   endfunction

   // true while the space-select lines are driven (T2..T4)
   function automatic logic in_data(input mxb_state_e s);
      return in_strobe(s) || (s == ST_T4);
   endfunction

endpackage

// File: rtl/mxb_ready_sync.sv
module mxb_ready_sync #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ready_i,
   output logic ready_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign ready_o = ready_i;
      end else begin : g_regs
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '1;
            end else begin
               sh_q[0] <= ready_i;
               for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign ready_o = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mxb_phase_timer.sv
module mxb_phase_timer #(
   parameter int CLKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic last_o,
   output logic first_half_o
);
   localparam int CW = (CLKS > 1) ? $clog2(CLKS) : 1;
   localparam logic [CW-1:0] LAST_V = CW'(CLKS - 1);
   localparam logic [CW-1:0] HALF_V = CW'(CLKS / 2);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run_i)     cnt_q <= '0;
      else if (last_o)     cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   assign last_o       = (cnt_q == LAST_V);
   assign first_half_o = (cnt_q < HALF_V);
endmodule

// File: rtl/mxb_seq.sv
module mxb_seq
   import mxb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BUS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [BUS_W-1:0]  req_wdata_i,
   input  logic              req_we_i,
   input  logic              req_io_i,
   input  logic              last_i,
   input  logic              ready_i,
   input  logic [BUS_W-1:0]  bus_i,
   output mxb_state_e        state_o,
   output logic              run_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BUS_W-1:0]  wdata_o,
   output logic              we_o,
   output logic              io_o,
   output logic [BUS_W-1:0]  rdata_o
);
   mxb_state_e st_q, st_d;
   logic       enter_t4;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (req_valid_i) st_d = ST_T1;
         ST_T1:   if (last_i) st_d = ST_T2;
         ST_T2:   if (last_i) st_d = ST_T3;
         ST_T3:   if (last_i) st_d = ready_i ? ST_T4 : ST_TW;
         ST_TW:   if (last_i && ready_i) st_d = ST_T4;
         ST_T4:   if (last_i) st_d = ST_DONE;
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   assign enter_t4 = ((st_q == ST_T3) || (st_q == ST_TW)) && last_i && ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_o  <= '0;
         wdata_o <= '0;
         we_o    <= 1'b0;
         io_o    <= 1'b0;
         rdata_o <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && req_valid_i) begin
            addr_o  <= req_addr_i;
            wdata_o <= req_wdata_i;
            we_o    <= req_we_i;
            io_o    <= req_io_i;
         end
         if (enter_t4 && !we_o) rdata_o <= bus_i;
      end
   end

   assign state_o = st_q;
   assign run_o   = (st_q != ST_IDLE) && (st_q != ST_DONE);
endmodule

// File: rtl/mxb_drive.sv
module mxb_drive
   import mxb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BUS_W  = 16
) (
   input  mxb_state_e        state_i,
   input  logic              first_half_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   input  logic              we_i,
   input  logic              io_i,
   output logic [BUS_W-1:0]  bus_o,
   output logic              bus_oe_o,
   output logic              ale_o,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic              mreq_n_o,
   output logic              iorq_n_o,
   output logic              done_o
);
   logic addr_ph, strobe_ph, data_ph;

   always_comb begin
      addr_ph   = (state_i == ST_T1);
      strobe_ph = in_strobe(state_i);
      data_ph   = in_data(state_i);

      cs_n_o   = !(addr_ph || data_ph);
      ale_o    = addr_ph && first_half_i;
      rd_n_o   = !(strobe_ph && !we_i);
      wr_n_o   = !(strobe_ph && we_i);
      mreq_n_o = !(data_ph && !io_i);
      iorq_n_o = !(data_ph && io_i);
      bus_oe_o = addr_ph || (data_ph && we_i);
      done_o   = (state_i == ST_DONE);

      if (addr_ph)              bus_o = BUS_W'(addr_i);
      else if (data_ph && we_i) bus_o = wdata_i;
      else                      bus_o = '0;
   end
endmodule

// File: rtl/mxb_bus_master.sv
module mxb_bus_master
   import mxb_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int BUS_W          = 16,
   parameter int CLKS_PER_STATE = 2,
   parameter int SYNC_STAGES    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [BUS_W-1:0]  req_wdata_i,
   input  logic              req_we_i,
   input  logic              req_io_i,
   output logic [BUS_W-1:0]  rdata_o,
   output logic              done_o,
   output logic [BUS_W-1:0]  bus_o,
   output logic              bus_oe_o,
   input  logic [BUS_W-1:0]  bus_i,
   output logic              ale_o,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic              mreq_n_o,
   output logic              iorq_n_o,
   input  logic              ready_i
);
   generate
      if (CLKS_PER_STATE < 2 || (CLKS_PER_STATE % 2) != 0) begin : g_bad_clks
         $error("CLKS_PER_STATE must be even and at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > BUS_W) begin : g_bad_addr
         $error("ADDR_W must be between 1 and BUS_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3 * CLKS_PER_STATE) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
   endgenerate

   mxb_state_e        st_w;
   logic              run_w, last_w, half_w, rdy_w, we_w, io_w;
   logic [ADDR_W-1:0] addr_w;
   logic [BUS_W-1:0]  wdata_w;

   mxb_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .ready_o(rdy_w)
   );

   mxb_phase_timer #(.CLKS(CLKS_PER_STATE)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(run_w),
      .last_o(last_w), .first_half_o(half_w)
   );

   mxb_seq #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
      .req_wdata_i(req_wdata_i), .req_we_i(req_we_i), .req_io_i(req_io_i),
      .last_i(last_w), .ready_i(rdy_w), .bus_i(bus_i),
      .state_o(st_w), .run_o(run_w), .addr_o(addr_w), .wdata_o(wdata_w),
      .we_o(we_w), .io_o(io_w), .rdata_o(rdata_o)
   );

   mxb_drive #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_drive (
      .state_i(st_w), .first_half_i(half_w), .addr_i(addr_w),
      .wdata_i(wdata_w), .we_i(we_w), .io_i(io_w),
      .bus_o(bus_o), .bus_oe_o(bus_oe_o), .ale_o(ale_o), .cs_n_o(cs_n_o),
      .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .mreq_n_o(mreq_n_o),
      .iorq_n_o(iorq_n_o), .done_o(done_o)
   );
endmodule

// File: rtl/mxb_bus_master_chk.sv
module mxb_bus_master_chk
   import mxb_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input mxb_state_e       state,
   input logic [BUS_W-1:0] bus_o,
   input logic             bus_oe_o,
   input logic             ale_o,
   input logic             cs_n_o,
   input logic             rd_n_o,
   input logic             wr_n_o,
   input logic             mreq_n_o,
   input logic             iorq_n_o,
   input logic             done_o
);
   // R3: both strobes never active together
   assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && !wr_n_o));

   // R4: memory and I/O request never active together
   assert_space_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mreq_n_o && !iorq_n_o));

   // R2: latch enable only while the address is driven under chip select
   assert_ale_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale_o |-> (bus_oe_o && !cs_n_o && rd_n_o && wr_n_o));

   // R2: every transfer opens with the latch enable high
   assert_cs_opens_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> ale_o);

   // R7: read strobe released while chip select is still active
   assert_rd_end_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n_o) |-> !cs_n_o);

   // R1: done lasts one clock and is followed by idle
   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && cs_n_o));

   // R5: outputs frozen inside T3
   assert_t3_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T3 && $past(state) == ST_T3) |->
         $stable({bus_o, bus_oe_o, ale_o, cs_n_o, rd_n_o, wr_n_o, mreq_n_o, iorq_n_o}));

   // R9: idle leaves the bus released
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (cs_n_o && rd_n_o && wr_n_o && !bus_oe_o && !ale_o));
endmodule

bind mxb_bus_master mxb_bus_master_chk #(.BUS_W(BUS_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .state(st_w), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
   .ale_o(ale_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
   .mreq_n_o(mreq_n_o), .iorq_n_o(iorq_n_o), .done_o(done_o)
);

// File: tb/mxb_bus_master_tb_top.sv
module mxb_bus_master_tb_top;
   localparam int AW = 16;
   localparam int BW = 16;
   localparam int N  = 2;
   localparam int S  = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [BW-1:0] req_wdata = '0;
   logic          req_we = 1'b0;
   logic          req_io = 1'b0;
   logic [BW-1:0] rdata;
   logic          done;
   logic [BW-1:0] bus_o;
   logic          bus_oe;
   logic [BW-1:0] bus_i = '0;
   logic          ale, cs_n, rd_n, wr_n, mreq_n, iorq_n;
   logic          ready = 1'b1;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   mxb_bus_master #(.ADDR_W(AW), .BUS_W(BW), .CLKS_PER_STATE(N), .SYNC_STAGES(S)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .req_we_i(req_we), .req_io_i(req_io),
      .rdata_o(rdata), .done_o(done), .bus_o(bus_o), .bus_oe_o(bus_oe),
      .bus_i(bus_i), .ale_o(ale), .cs_n_o(cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
      .mreq_n_o(mreq_n), .iorq_n_o(iorq_n), .ready_i(ready)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         if (errors < 40)
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] drive_val(input int j, input int seed);
      return BW'(j * 16'h0131 + seed * 16'h0707 + 16'h5A3C);
   endfunction

   // one transfer; ready rises at the negedge after posedge p (p=0: high from the start)
   task automatic run_xfer(input logic we, input logic io, input int p,
                           input logic [AW-1:0] a, input logic [BW-1:0] d, input int seed);
      int h, w, tot;
      logic [BW-1:0] cap_exp;
      logic [9:0] snap;
      h = p;
      w = (h <= 3*N - S) ? 0 : (h - 3*N + S + N - 1) / N;
      tot = (4 + w) * N;
      cap_exp = drive_val((3 + w) * N, seed);
      snap = '0;
      req_valid = 1'b1; req_addr = a; req_wdata = d; req_we = we; req_io = io;
      ready = (p == 0); bus_i = drive_val(0, seed);
      for (int k = 1; k <= tot + 4; k++) begin
         int t, ph;
         logic active, strobe, exp_oe;
         @(negedge clk);
         t = k - 1;
         ph = t / N;
         active = (t >= N) && (t < tot);
         strobe = (t >= N) && (t < (3 + w) * N);
         exp_oe = (t < N) || (we && active);
         if (t < tot) begin
            chk("R1", "cs_n", cs_n, 0);
            if (t < N) begin
               chk("R2", "ale", ale, ((t % N) < N/2));
               chk("R2", "oe in T1", bus_oe, 1);
               chk("R10", "address held", bus_o, BW'(a));
            end else begin
               chk("R2", "ale after T1", ale, 0);
               chk("R3", "rd_n", rd_n, !(strobe && !we));
               chk("R3", "wr_n", wr_n, !(strobe && we));
               chk("R4", "mreq_n", mreq_n, io);
               chk("R4", "iorq_n", iorq_n, !io);
               if (we) begin
                  chk(strobe ? "R3" : "R8", "oe write", bus_oe, 1);
                  chk("R10", "write data held", bus_o, d);
               end else begin
                  chk("R3", "oe read", bus_oe, 0);
               end
               if (t == 2*N - 1) snap = {bus_oe, ale, cs_n, rd_n, wr_n, mreq_n, iorq_n, bus_o[2:0]};
               if (ph == 2)
                  chk("R5", "T3 frozen", {bus_oe, ale, cs_n, rd_n, wr_n, mreq_n, iorq_n, bus_o[2:0]}, snap);
               if (t >= (3 + w) * N && we)
                  chk("R8", "wr_n in T4", wr_n, 1);
            end
            chk("R1", "done early", done, 0);
         end else begin
            chk("R1 R6", "done", done, (t == tot));
            chk("R9", "idle cs_n", cs_n, 1);
            chk("R9", "idle strobes", {rd_n, wr_n, mreq_n, iorq_n}, 4'hF);
            chk("R9", "idle oe/ale", {bus_oe, ale}, 2'b00);
            chk("R10", "no second transfer", cs_n, 1);
         end
         if (t == tot && !we) chk("R7", "read capture", rdata, cap_exp);
         // drives for the next clock
         req_valid = (k == 2);
         if (k == 2) begin
            req_addr = ~a; req_wdata = ~d; req_we = ~we; req_io = ~io;
         end
         ready = (k >= p);
         bus_i = drive_val(k, seed);
      end
      if (!we) chk("R7", "read data held", rdata, cap_exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9", "reset cs_n", cs_n, 1);
      chk("R9", "reset strobes", {rd_n, wr_n, mreq_n, iorq_n}, 4'hF);
      chk("R9", "reset oe/ale/done", {bus_oe, ale, done}, 3'b000);
      chk("R9", "reset bus", bus_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int we = 0; we < 2; we++)
         for (int io = 0; io < 2; io++)
            for (int p = 0; p <= 14; p++)
               run_xfer(we[0], io[0], p, AW'(16'hA000 + p * 16'h0111 + io * 16'h0020),
                        BW'(16'h3C00 + p * 16'h0105 + we * 16'h0042), p + 3*io);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end
endmodule